// File: doc/BRIEF.md
# Special-Purpose Register Bank

This block holds a processor's special-purpose registers and serves the two instructions that reach them. One moves a general register into a special register, and the other moves a special register back out. Each instruction forms its register address by ORing the low 16 bits of a base operand with a 16-bit immediate. The top five address bits select a group and the low eleven bits select a register within that group.

Most of the bank is not plain storage. The interrupt-mask register can only gain bits, and the interrupt-status register loses the bits a write names. The status register keeps one bit fixed at 1. The tick-timer mode register either keeps or drops its pending bit, depending on the value written. The bank also holds way 0 of the data and the instruction translation buffers, each with a match array and a translate array.

The translation datapath, the timer counting engine and the flush machinery sit outside the block. The bank only sends them one-cycle strobes: a full flush, a page flush with its address, timer start, timer stop, pending-interrupt drop and counter load. A move-from is combinational. A move-to takes effect at the next clock edge, and its strobes appear in the cycle after that edge.

Top module: `spr_bank`

## Requirements
- R1: The effective address is `base[15:0] | imm`, with group = address[15:11] and number = address[10:0]. The version register (0/0), next PC (0/16), previous PC (0/18), exception PC (0/32), exception address (0/48) and exception status (0/64) store the written word. A move-from returns the stored word in the same cycle.
- R2: The status register (0/17) resets to 0x0000_8001. Every write to it stores the written value with bit 15 forced to 1.
- R3: A status write that changes bit 0 (supervisor), bit 5 (data-MMU enable) or bit 6 (instruction-MMU enable) pulses `tlb_flush_all` for exactly one cycle, in the cycle after the write edge. A write that changes none of these bits leaves the strobe low.
- R4: A write to the interrupt-mask register (9/0) ORs the data into the current mask, so a write never clears a mask bit.
- R5: A write to the interrupt-status register (9/2) clears each bit that is 1 in the data. `pic_raise` sets status bits, and a raise wins over a clear in the same cycle.
- R6: On a write to the timer mode register (10/0), a written bit 28 of 1 keeps the current pending bit. A written bit 28 of 0 clears the pending bit and pulses `tmr_irq_drop`. `tmr_ip_raise` sets the pending bit.
- R7: When a timer mode write changes the mode field (bits 31:30), a new mode of 0 pulses `tmr_stop` and any other new mode pulses `tmr_start`. A write that leaves the mode field unchanged pulses neither strobe.
- R8: A write to the timer count register (10/1) pulses `cnt_load` with the data on `cnt_load_val`. A move-from of that register returns `tick_count` as it is in the same cycle.
- R9: In group 1, number 512+i is data-side match entry i and 640+i is data-side translate entry i. Group 2 uses the same layout for the instruction side. Each entry stores and returns a full word.
- R10: A write to a match entry with bit 0 equal to 0 pulses `page_flush` one cycle later. `page_flush_addr` carries the entry's previous value with its low PAGE_BITS bits cleared, and `page_flush_inst` is 1 for the instruction side.
- R11: Writes to numbers 768–1535 of groups 1 and 2, and to any undecoded address, change no state. A move-from of those addresses returns `mf_dest`.
- R12: The unit-present (0/1), CPU-config (0/2), data-MMU config (0/3) and instruction-MMU config (0/4) registers read back their parameter values, and writes to them are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mt_en | input | 1 | Move-to request |
| mt_base | input | DATA_W | Move-to base operand |
| mt_imm | input | 16 | Move-to immediate offset |
| mt_data | input | DATA_W | Move-to data |
| mf_en | input | 1 | Move-from request |
| mf_base | input | DATA_W | Move-from base operand |
| mf_imm | input | 16 | Move-from immediate offset |
| mf_dest | input | DATA_W | Old destination register value |
| mf_data | output | DATA_W | Move-from result |
| pic_raise | input | DATA_W | Interrupt lines that set status bits |
| tmr_ip_raise | input | 1 | Timer engine sets the pending bit |
| tick_count | input | DATA_W | Live timer counter |
| tlb_flush_all | output | 1 | Full translation flush strobe |
| page_flush | output | 1 | Page flush strobe |
| page_flush_inst | output | 1 | Page flush targets the instruction side |
| page_flush_addr | output | DATA_W | Page address to flush |
| tmr_start | output | 1 | Start the counter |
| tmr_stop | output | 1 | Stop the counter |
| tmr_irq_drop | output | 1 | Drop the pending timer interrupt |
| cnt_load | output | 1 | Load the counter |
| cnt_load_val | output | DATA_W | Counter load value |

## Verification
A corrupted mask, status or mode register appears at the ports at the next move-from of that register. It also shows in the strobes of the next write to it: a wrong old value sends a false or missing flush, start or stop one cycle after that write. A wrong value in a stored match entry may stay hidden until the entry is read or invalidated. When it is invalidated, the flush address carries the error. The bench therefore reads back after every write and checks each strobe in the exact cycle after the edge, as well as the idle cycle after it.

// File: rtl/spr_pkg.sv
package spr_pkg;
   localparam int ADDR_W     = 16;
   localparam int NUM_W      = 11;
   localparam int SR_SM      = 0;
   localparam int SR_DME     = 5;
   localparam int SR_IME     = 6;
   localparam int SR_FO      = 15;
   localparam int TM_IP      = 28;
   localparam int TM_MODE_LO = 30;

   typedef enum logic [4:0] {
      K_NONE, K_VR, K_UPR, K_CPUCFG, K_DMMUCFG, K_IMMUCFG,
      K_NPC, K_SR, K_PPC, K_EPC, K_EEA, K_ESTAT,
      K_PICM, K_PICS, K_TMODE, K_TCOUNT,
      K_DMATCH, K_DXLAT, K_IMATCH, K_IXLAT
   } spr_kind_e;
endpackage

// File: rtl/spr_addr_dec.sv
module spr_addr_dec
   import spr_pkg::*;
#(
   parameter int TLB_SETS = 128,
   parameter int IDX_W    = $clog2(TLB_SETS)
) (
   input  logic [ADDR_W-1:0] addr,
   output spr_kind_e         kind,
   output logic [IDX_W-1:0]  idx
);
   logic [4:0]       grp;
   logic [NUM_W-1:0] num;
   logic             in_sets;

   always_comb begin
      grp     = addr[ADDR_W-1:NUM_W];
      num     = addr[NUM_W-1:0];
      idx     = num[IDX_W-1:0];
      in_sets = (32'(num[6:0]) < TLB_SETS);
      kind    = K_NONE;
      case (grp)
         5'd0: case (num)
            11'd0:   kind = K_VR;
            11'd1:   kind = K_UPR;
            11'd2:   kind = K_CPUCFG;
            11'd3:   kind = K_DMMUCFG;
            11'd4:   kind = K_IMMUCFG;
            11'd16:  kind = K_NPC;
            11'd17:  kind = K_SR;
            11'd18:  kind = K_PPC;
            11'd32:  kind = K_EPC;
            11'd48:  kind = K_EEA;
            11'd64:  kind = K_ESTAT;
            default: kind = K_NONE;
         endcase
         5'd1, 5'd2: begin
            if (in_sets && num[10:7] == 4'd4)
               kind = (grp == 5'd1) ? K_DMATCH : K_IMATCH;
            else if (in_sets && num[10:7] == 4'd5)
               kind = (grp == 5'd1) ? K_DXLAT : K_IXLAT;
         end
         5'd9: begin
            if (num == 11'd0)      kind = K_PICM;
            else if (num == 11'd2) kind = K_PICS;
         end
         5'd10: begin
            if (num == 11'd0)      kind = K_TMODE;
            else if (num == 11'd1) kind = K_TCOUNT;
         end
         default: kind = K_NONE;
      endcase
   end
endmodule

// File: rtl/spr_tlb_side.sv
module spr_tlb_side #(
   parameter int DATA_W    = 32,
   parameter int SETS      = 128,
   parameter int IDX_W     = $clog2(SETS),
   parameter int PAGE_BITS = 13
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_match,
   input  logic              wr_xlat,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [IDX_W-1:0]  rd_idx,
   output logic [DATA_W-1:0] rd_match,
   output logic [DATA_W-1:0] rd_xlat,
   output logic              flush_req,
   output logic [DATA_W-1:0] flush_addr
);
   localparam logic [DATA_W-1:0] PAGE_MASK = ~((DATA_W'(1) << PAGE_BITS) - DATA_W'(1));

   logic [DATA_W-1:0] match_q [SETS];
   logic [DATA_W-1:0] xlat_q  [SETS];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < SETS; i++) begin
            match_q[i] <= '0;
            xlat_q[i]  <= '0;
         end
      end else begin
         if (wr_match) match_q[wr_idx] <= wr_data;
         if (wr_xlat)  xlat_q[wr_idx]  <= wr_data;
      end
   end

   assign rd_match   = match_q[rd_idx];
   assign rd_xlat    = xlat_q[rd_idx];
   assign flush_req  = wr_match && !wr_data[0];
   assign flush_addr = match_q[wr_idx] & PAGE_MASK;
endmodule

// File: rtl/spr_tick_ctl.sv
module spr_tick_ctl
   import spr_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mode_we,
   input  logic              count_we,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              ip_raise,
   output logic [DATA_W-1:0] mode_q,
   output logic              start_o,
   output logic              stop_o,
   output logic              drop_o,
   output logic              load_o,
   output logic [DATA_W-1:0] load_val_o
);
   logic [DATA_W-1:0] mode_nxt;
   logic [1:0]        new_mode;

   always_comb begin
      new_mode = wr_data[TM_MODE_LO +: 2];
      mode_nxt = mode_we ? wr_data : mode_q;
      mode_nxt[TM_IP] = (mode_we ? (wr_data[TM_IP] & mode_q[TM_IP]) : mode_q[TM_IP])
                        | ip_raise;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode_q     <= '0;
         start_o    <= 1'b0;
         stop_o     <= 1'b0;
         drop_o     <= 1'b0;
         load_o     <= 1'b0;
         load_val_o <= '0;
      end else begin
         mode_q  <= mode_nxt;
         start_o <= mode_we && (new_mode != mode_q[TM_MODE_LO +: 2]) && (new_mode != 2'd0);
         stop_o  <= mode_we && (new_mode != mode_q[TM_MODE_LO +: 2]) && (new_mode == 2'd0);
         drop_o  <= mode_we && !wr_data[TM_IP];
         load_o  <= count_we;
         if (count_we) load_val_o <= wr_data;
      end
   end
endmodule

// File: rtl/spr_bank.sv
module spr_bank
   import spr_pkg::*;
#(
   parameter int          DATA_W    = 32,
   parameter int          TLB_SETS  = 128,
   parameter int          PAGE_BITS = 13,
   parameter logic [31:0] VERSION   = 32'h1200_0001,
   parameter logic [31:0] UNIT_CFG  = 32'h0000_0619,
   parameter logic [31:0] CPU_CFG   = 32'h0000_0020,
   parameter logic [31:0] DMMU_CFG  = 32'h0000_0018,
   parameter logic [31:0] IMMU_CFG  = 32'h0000_0018
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mt_en,
   input  logic [DATA_W-1:0] mt_base,
   input  logic [15:0]       mt_imm,
   input  logic [DATA_W-1:0] mt_data,
   input  logic              mf_en,
   input  logic [DATA_W-1:0] mf_base,
   input  logic [15:0]       mf_imm,
   input  logic [DATA_W-1:0] mf_dest,
   output logic [DATA_W-1:0] mf_data,
   input  logic [DATA_W-1:0] pic_raise,
   input  logic              tmr_ip_raise,
   input  logic [DATA_W-1:0] tick_count,
   output logic              tlb_flush_all,
   output logic              page_flush,
   output logic              page_flush_inst,
   output logic [DATA_W-1:0] page_flush_addr,
   output logic              tmr_start,
   output logic              tmr_stop,
   output logic              tmr_irq_drop,
   output logic              cnt_load,
   output logic [DATA_W-1:0] cnt_load_val
);
   localparam int IDX_W = $clog2(TLB_SETS);
   localparam logic [DATA_W-1:0] FO_BIT     = DATA_W'(1) << SR_FO;
   localparam logic [DATA_W-1:0] SR_RESET   = FO_BIT | (DATA_W'(1) << SR_SM);
   localparam logic [DATA_W-1:0] FLUSH_MASK = (DATA_W'(1) << SR_SM) |
                                              (DATA_W'(1) << SR_DME) |
                                              (DATA_W'(1) << SR_IME);

   if (DATA_W < 32) begin : g_bad_width
      $error("spr_bank: DATA_W must be at least 32");
   end
   if (TLB_SETS < 2 || TLB_SETS > 128 || (TLB_SETS & (TLB_SETS - 1)) != 0) begin : g_bad_sets
      $error("spr_bank: TLB_SETS must be a power of two from 2 to 128");
   end
   if (PAGE_BITS < 1 || PAGE_BITS >= DATA_W) begin : g_bad_page
      $error("spr_bank: PAGE_BITS out of range");
   end

   spr_kind_e         mt_kind, mf_kind;
   logic [IDX_W-1:0]  mt_idx, mf_idx;
   logic [DATA_W-1:0] vr_q, npc_q, sr_q, ppc_q, epc_q, eea_q, estat_q;
   logic [DATA_W-1:0] picm_q, pics_q, tmode_q;
   logic              sr_we;

   spr_addr_dec #(.TLB_SETS(TLB_SETS), .IDX_W(IDX_W)) u_mt_dec (
      .addr(mt_base[ADDR_W-1:0] | mt_imm), .kind(mt_kind), .idx(mt_idx));
   spr_addr_dec #(.TLB_SETS(TLB_SETS), .IDX_W(IDX_W)) u_mf_dec (
      .addr(mf_base[ADDR_W-1:0] | mf_imm), .kind(mf_kind), .idx(mf_idx));

   // Side 0 is the data buffer, side 1 the instruction buffer.
   logic [1:0]        side_wm, side_wx, side_flush;
   logic [DATA_W-1:0] side_rm [2];
   logic [DATA_W-1:0] side_rx [2];
   logic [DATA_W-1:0] side_fa [2];

   assign side_wm[0] = mt_en && (mt_kind == K_DMATCH);
   assign side_wx[0] = mt_en && (mt_kind == K_DXLAT);
   assign side_wm[1] = mt_en && (mt_kind == K_IMATCH);
   assign side_wx[1] = mt_en && (mt_kind == K_IXLAT);

   for (genvar s = 0; s < 2; s++) begin : g_side
      spr_tlb_side #(.DATA_W(DATA_W), .SETS(TLB_SETS), .IDX_W(IDX_W),
                     .PAGE_BITS(PAGE_BITS)) u_side (
         .clk(clk), .rst_n(rst_n),
         .wr_match(side_wm[s]), .wr_xlat(side_wx[s]),
         .wr_idx(mt_idx), .wr_data(mt_data), .rd_idx(mf_idx),
         .rd_match(side_rm[s]), .rd_xlat(side_rx[s]),
         .flush_req(side_flush[s]), .flush_addr(side_fa[s]));
   end

   spr_tick_ctl #(.DATA_W(DATA_W)) u_tick (
      .clk(clk), .rst_n(rst_n),
      .mode_we(mt_en && mt_kind == K_TMODE),
      .count_we(mt_en && mt_kind == K_TCOUNT),
      .wr_data(mt_data), .ip_raise(tmr_ip_raise),
      .mode_q(tmode_q), .start_o(tmr_start), .stop_o(tmr_stop),
      .drop_o(tmr_irq_drop), .load_o(cnt_load), .load_val_o(cnt_load_val));

   assign sr_we = mt_en && (mt_kind == K_SR);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vr_q    <= DATA_W'(VERSION);
         npc_q   <= '0;
         sr_q    <= SR_RESET;
         ppc_q   <= '0;
         epc_q   <= '0;
         eea_q   <= '0;
         estat_q <= '0;
         picm_q  <= '0;
         pics_q  <= '0;
         tlb_flush_all   <= 1'b0;
         page_flush      <= 1'b0;
         page_flush_inst <= 1'b0;
         page_flush_addr <= '0;
      end else begin
         if (mt_en) begin
            case (mt_kind)
               K_VR:    vr_q    <= mt_data;
               K_NPC:   npc_q   <= mt_data;
               K_SR:    sr_q    <= mt_data | FO_BIT;
               K_PPC:   ppc_q   <= mt_data;
               K_EPC:   epc_q   <= mt_data;
               K_EEA:   eea_q   <= mt_data;
               K_ESTAT: estat_q <= mt_data;
               K_PICM:  picm_q  <= picm_q | mt_data;
               default: ;
            endcase
         end
         pics_q <= ((mt_en && mt_kind == K_PICS) ? (pics_q & ~mt_data) : pics_q) | pic_raise;
         tlb_flush_all <= sr_we && (((sr_q ^ mt_data) & FLUSH_MASK) != '0);
         page_flush    <= |side_flush;
         if (|side_flush) begin
            page_flush_inst <= side_flush[1];
            page_flush_addr <= side_flush[1] ? side_fa[1] : side_fa[0];
         end
      end
   end

   always_comb begin
      mf_data = mf_dest;
      if (mf_en) begin
         case (mf_kind)
            K_VR:      mf_data = vr_q;
            K_UPR:     mf_data = DATA_W'(UNIT_CFG);
            K_CPUCFG:  mf_data = DATA_W'(CPU_CFG);
            K_DMMUCFG: mf_data = DATA_W'(DMMU_CFG);
            K_IMMUCFG: mf_data = DATA_W'(IMMU_CFG);
            K_NPC:     mf_data = npc_q;
            K_SR:      mf_data = sr_q;
            K_PPC:     mf_data = ppc_q;
            K_EPC:     mf_data = epc_q;
            K_EEA:     mf_data = eea_q;
            K_ESTAT:   mf_data = estat_q;
            K_PICM:    mf_data = picm_q;
            K_PICS:    mf_data = pics_q;
            K_TMODE:   mf_data = tmode_q;
            K_TCOUNT:  mf_data = tick_count;
            K_DMATCH:  mf_data = side_rm[0];
            K_DXLAT:   mf_data = side_rx[0];
            K_IMATCH:  mf_data = side_rm[1];
            K_IXLAT:   mf_data = side_rx[1];
            default:   mf_data = mf_dest;
         endcase
      end
   end
endmodule

// File: rtl/spr_bank_chk.sv
module spr_bank_chk
   import spr_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              mt_en,
   input spr_kind_e         mt_kind,
   input logic [DATA_W-1:0] mt_data,
   input logic [DATA_W-1:0] sr_q,
   input logic [DATA_W-1:0] picm_q,
   input logic              tlb_flush_all,
   input logic              page_flush,
   input logic              tmr_start,
   input logic              tmr_stop,
   input logic              mf_en,
   input spr_kind_e         mf_kind,
   input logic [DATA_W-1:0] mf_data,
   input logic [DATA_W-1:0] mf_dest
);
   localparam logic [DATA_W-1:0] CHG = (DATA_W'(1) << SR_SM) |
                                       (DATA_W'(1) << SR_DME) |
                                       (DATA_W'(1) << SR_IME);
   logic sr_chg;
   assign sr_chg = mt_en && (mt_kind == K_SR) && (((sr_q ^ mt_data) & CHG) != '0);

   p_fixed_one_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (mt_en && mt_kind == K_SR) |=> sr_q[SR_FO]);

   p_flush_on_change_r3: assert property (@(posedge clk) disable iff (!rst_n)
      sr_chg |=> tlb_flush_all);

   p_no_spurious_flush_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !sr_chg |=> !tlb_flush_all);

   p_mask_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((picm_q & $past(picm_q)) == $past(picm_q)));

   p_start_stop_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !(tmr_start && tmr_stop));

   p_page_flush_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (mt_en && (mt_kind == K_DMATCH || mt_kind == K_IMATCH) && !mt_data[0]) |=> page_flush);

   p_unimpl_read_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (mf_en && mf_kind == K_NONE) |-> (mf_data == mf_dest));
endmodule

bind spr_bank spr_bank_chk #(.DATA_W(DATA_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .mt_en(mt_en), .mt_kind(mt_kind), .mt_data(mt_data),
   .sr_q(sr_q), .picm_q(picm_q), .tlb_flush_all(tlb_flush_all),
   .page_flush(page_flush), .tmr_start(tmr_start), .tmr_stop(tmr_stop),
   .mf_en(mf_en), .mf_kind(mf_kind), .mf_data(mf_data), .mf_dest(mf_dest));

// File: tb/spr_bank_bench.sv
module spr_bank_bench;
   localparam int DW = 32;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          mt_en = 1'b0;
   logic [DW-1:0] mt_base = '0;
   logic [15:0]   mt_imm = '0;
   logic [DW-1:0] mt_data = '0;
   logic          mf_en = 1'b0;
   logic [DW-1:0] mf_base = '0;
   logic [15:0]   mf_imm = '0;
   logic [DW-1:0] mf_dest = '0;
   logic [DW-1:0] mf_data;
   logic [DW-1:0] pic_raise = '0;
   logic          tmr_ip_raise = 1'b0;
   logic [DW-1:0] tick_count = '0;
   logic          tlb_flush_all, page_flush, page_flush_inst;
   logic [DW-1:0] page_flush_addr;
   logic          tmr_start, tmr_stop, tmr_irq_drop, cnt_load;
   logic [DW-1:0] cnt_load_val;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #5 clk = ~clk;

   spr_bank u_spr_bank (
      .clk(clk), .rst_n(rst_n),
      .mt_en(mt_en), .mt_base(mt_base), .mt_imm(mt_imm), .mt_data(mt_data),
      .mf_en(mf_en), .mf_base(mf_base), .mf_imm(mf_imm), .mf_dest(mf_dest),
      .mf_data(mf_data), .pic_raise(pic_raise), .tmr_ip_raise(tmr_ip_raise),
      .tick_count(tick_count), .tlb_flush_all(tlb_flush_all),
      .page_flush(page_flush), .page_flush_inst(page_flush_inst),
      .page_flush_addr(page_flush_addr), .tmr_start(tmr_start), .tmr_stop(tmr_stop),
      .tmr_irq_drop(tmr_irq_drop), .cnt_load(cnt_load), .cnt_load_val(cnt_load_val));

   task automatic check(input string tag, input logic [DW-1:0] got, input logic [DW-1:0] exp);
      checks++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s: got 0x%08h expected 0x%08h", tag, got, exp);
      end
   endtask

   // Write split across base and immediate; returns at the negedge after the write edge.
   task automatic wr(input logic [15:0] base, input logic [15:0] imm, input logic [DW-1:0] d);
      @(negedge clk);
      mt_en = 1'b1; mt_base = {16'h0, base}; mt_imm = imm; mt_data = d;
      @(negedge clk);
      mt_en = 1'b0;
   endtask

   task automatic rd(input logic [15:0] addr, input logic [DW-1:0] dest, output logic [DW-1:0] v);
      mf_en = 1'b1; mf_base = {16'h0, addr & 16'hFF00}; mf_imm = addr & 16'h00FF; mf_dest = dest;
      #1 v = mf_data;
      mf_en = 1'b0;
   endtask

   task automatic idle();
      @(negedge clk);
   endtask

   task automatic t_reset();
      logic [DW-1:0] v;
      rd(16'h0011, '0, v);            check("R2 status reset", v, 32'h0000_8001);
      rd(16'h4800, '0, v);            check("R4 mask reset", v, 32'h0);
      check("R3 flush idle at reset", {31'b0, tlb_flush_all}, 32'h0);
   endtask

   task automatic t_plain();
      logic [DW-1:0] v;
      wr(16'h0010, 16'h0000, 32'h1234_5678);
      rd(16'h0010, '0, v);            check("R1 next pc", v, 32'h1234_5678);
      wr(16'h0020, 16'h0010, 32'hA5A5_0001);   // 0x20|0x10 = 0x30
      rd(16'h0030, '0, v);            check("R1 exception address via OR", v, 32'hA5A5_0001);
      rd(16'h0020, '0, v);            check("R1 exception pc untouched", v, 32'h0);
      wr(16'h0000, 16'h0040, 32'h0000_BEEF);
      rd(16'h0040, '0, v);            check("R1 exception status", v, 32'h0000_BEEF);
   endtask

   task automatic t_status();
      logic [DW-1:0] v;
      wr(16'h0000, 16'h0011, 32'h0000_0001);
      check("R3 no flush on same bits", {31'b0, tlb_flush_all}, 32'h0);
      rd(16'h0011, '0, v);            check("R2 fixed one", v, 32'h0000_8001);
      wr(16'h0000, 16'h0011, 32'h0000_0020);
      check("R3 flush on change", {31'b0, tlb_flush_all}, 32'h1);
      rd(16'h0011, '0, v);            check("R2 fixed one forced", v, 32'h0000_8020);
      idle();
      check("R3 flush one cycle", {31'b0, tlb_flush_all}, 32'h0);
      wr(16'h0000, 16'h0011, 32'h0000_8022);
      check("R3 other bits no flush", {31'b0, tlb_flush_all}, 32'h0);
   endtask

   task automatic t_pic();
      logic [DW-1:0] v;
      wr(16'h4800, 16'h0000, 32'h0F);
      wr(16'h4800, 16'h0000, 32'h30);
      rd(16'h4800, '0, v);            check("R4 mask or", v, 32'h3F);
      wr(16'h4800, 16'h0000, 32'h0);
      rd(16'h4800, '0, v);            check("R4 mask kept", v, 32'h3F);
      @(negedge clk); pic_raise = 32'hFF;
      @(negedge clk); pic_raise = '0;
      rd(16'h4802, '0, v);            check("R5 status raised", v, 32'hFF);
      wr(16'h4800, 16'h0002, 32'h0F);
      rd(16'h4802, '0, v);            check("R5 status cleared", v, 32'hF0);
   endtask

   task automatic t_timer();
      logic [DW-1:0] v;
      wr(16'h5000, 16'h0000, 32'h4000_0000);
      check("R7 start", {30'b0, tmr_start, tmr_stop}, 32'h2);
      check("R6 drop on ip zero", {31'b0, tmr_irq_drop}, 32'h1);
      @(negedge clk); tmr_ip_raise = 1'b1;
      @(negedge clk); tmr_ip_raise = 1'b0;
      rd(16'h5000, '0, v);            check("R6 ip raised", v, 32'h5000_0000);
      wr(16'h5000, 16'h0000, 32'h5000_0000);
      check("R7 same mode no strobe", {30'b0, tmr_start, tmr_stop}, 32'h0);
      check("R6 keep no drop", {31'b0, tmr_irq_drop}, 32'h0);
      rd(16'h5000, '0, v);            check("R6 ip kept", v, 32'h5000_0000);
      wr(16'h5000, 16'h0000, 32'h4000_0000);
      rd(16'h5000, '0, v);            check("R6 ip cleared", v, 32'h4000_0000);
      check("R6 drop", {31'b0, tmr_irq_drop}, 32'h1);
      wr(16'h5000, 16'h0000, 32'h8000_0000);
      check("R7 mode change start", {30'b0, tmr_start, tmr_stop}, 32'h2);
      wr(16'h5000, 16'h0000, 32'h0000_0000);
      check("R7 stop", {30'b0, tmr_start, tmr_stop}, 32'h1);
   endtask

   task automatic t_count();
      logic [DW-1:0] v;
      wr(16'h5000, 16'h0001, 32'h55);
      check("R8 load strobe", {31'b0, cnt_load}, 32'h1);
      check("R8 load value", cnt_load_val, 32'h55);
      tick_count = 32'h0000_ABCD;
      rd(16'h5001, '0, v);            check("R8 live count", v, 32'h0000_ABCD);
   endtask

   task automatic t_tlb();
      logic [DW-1:0] v;
      wr(16'h0A00, 16'h0005, 32'hDEAD_E001);
      check("R10 valid write no flush", {31'b0, page_flush}, 32'h0);
      rd(16'h0A05, '0, v);            check("R9 data match", v, 32'hDEAD_E001);
      wr(16'h0A80, 16'h0005, 32'h0000_1111);
      check("R10 translate no flush", {31'b0, page_flush}, 32'h0);
      rd(16'h0A85, '0, v);            check("R9 data translate", v, 32'h0000_1111);
      wr(16'h0A00, 16'h0005, 32'h0000_0000);
      check("R10 page flush", {31'b0, page_flush}, 32'h1);
      check("R10 page addr", page_flush_addr, 32'hDEAD_E000);
      check("R10 data side", {31'b0, page_flush_inst}, 32'h0);
      wr(16'h1200, 16'h007F, 32'h0000_4000);
      check("R10 inst flush", {31'b0, page_flush}, 32'h1);
      check("R10 inst side", {31'b0, page_flush_inst}, 32'h1);
      check("R10 inst addr", page_flush_addr, 32'h0);
      rd(16'h127F, '0, v);            check("R9 inst match", v, 32'h0000_4000);
   endtask

   task automatic t_ignored();
      logic [DW-1:0] v;
      wr(16'h0B00, 16'h0000, 32'h0000_0776);
      check("R11 no page flush", {31'b0, page_flush}, 32'h0);
      rd(16'h0B00, 32'h0000_CAFE, v); check("R11 way1 read dest", v, 32'h0000_CAFE);
      rd(16'h0A00, '0, v);            check("R11 way0 entry untouched", v, 32'h0);
      wr(16'h7F00, 16'h00FF, 32'hFFFF_FFFF);
      rd(16'h7FFF, 32'h0000_1357, v); check("R11 undecoded read dest", v, 32'h0000_1357);
      rd(16'h0011, '0, v);            check("R11 status untouched", v, 32'h0000_8022);
   endtask

   task automatic t_config();
      logic [DW-1:0] v;
      rd(16'h0001, '0, v);            check("R12 unit cfg", v, 32'h0000_0619);
      wr(16'h0000, 16'h0001, 32'h0);
      rd(16'h0001, '0, v);            check("R12 unit cfg write ignored", v, 32'h0000_0619);
      rd(16'h0003, '0, v);            check("R12 dmmu cfg", v, 32'h0000_0018);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_plain();
      t_status();
      t_pic();
      t_timer();
      t_count();
      t_tlb();
      t_ignored();
      t_config();
      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (200000) @(posedge clk);
            checks++; fails++;
            $display("FAIL watchdog: got timeout expected completion");
         end
      join_any
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule